// File: doc/BRIEF.md
# Trigger-Synchronized Timer Pair

Two 16-bit up-counters share one clock and are chained so that a single rising edge on an external pin starts both. Timer A watches the pin through a two-flop synchronizer and an edge detector. In trigger mode, that edge turns on A's counter-enable. A exports its counter-enable as a trigger output. Timer B takes A's trigger output as its own trigger and so starts one cycle later.

Each timer has a small write-only register set. It holds the trigger-source, slave-mode and master-mode fields, a compensation bit, a debug-freeze enable, an update strobe, a loadable counter and a sticky trigger flag. When the compensation bit is set on A, A's counting is held back by one cycle. A and B then show identical counts on every cycle. Preloading either counter before the trigger gives a fixed offset between the two. A debug-halt input freezes each counter whose freeze enable is set.

Top module: `trig_timer_pair`

## Requirements
- R1: After reset both counters read 0, both trigger flags are 0 and both trigger outputs are low.
- R2: Writes go to register `wr_addr_i[1:0]` of timer `wr_addr_i[2]`, where 0 selects A and 1 selects B. Register 0 is control, with trigger source in [2:0], slave mode in [5:3], master mode in [8:6], compensation in [9] and freeze enable in [10]. With trigger source 100 (external pin) and slave mode 110 (trigger mode), a pin that is first seen high at clock edge P0 sets A's flag at edge P2. A's counter reaches 1 at edge P3 when compensation is clear, and then increments once per clock.
- R3: Trigger source 001 selects the other timer's trigger output. Master mode 001 drives the trigger output with the counter-enable. With A configured this way and B in trigger mode on source 001, B's flag sets at P3 and B's counter reaches 1 at P4. A then leads B by exactly one count on every cycle.
- R4: With compensation set, A's counter reaches 1 at P4. From then on A and B hold the same value (plus any preload difference) on every cycle.
- R5: A slave-mode value other than 110 ignores trigger edges: the counter stays unchanged and the flag stays 0.
- R6: Master mode 000 drives the trigger output with a one-cycle pulse in the cycle after an update strobe. Any master-mode value other than 000 or 001 keeps the trigger output low.
- R7: Writing register 1 with bit 0 = 1 clears the counter to 0 at that clock edge. This takes priority over an increment in the same cycle.
- R8: Writing register 2 loads the counter with the written value. This sets an offset between the timers.
- R9: An enabled counter wraps from 0xFFFF to 0x0000.
- R10: Once the counter-enable is set, a later trigger edge does not restart the count, but it does set the flag again.
- R11: The flag stays set until register 3 is written with bit 0 = 0. Writing bit 0 = 1 has no effect. If a trigger edge and a clearing write land in the same cycle, the flag ends up set.
- R12: While `dbg_halt_i` is high, a timer with freeze enable set holds its counter. A timer with freeze enable clear keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_trig_i | input | 1 | External trigger pin, asynchronous |
| dbg_halt_i | input | 1 | Debug halt indication |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Timer select [2] and register select [1:0] |
| wr_data_i | input | 16 | Write data |
| cnt_a_o | output | 16 | Timer A counter |
| cnt_b_o | output | 16 | Timer B counter |
| tif_a_o | output | 1 | Timer A trigger flag |
| tif_b_o | output | 1 | Timer B trigger flag |
| trgo_a_o | output | 1 | Timer A trigger output |
| trgo_b_o | output | 1 | Timer B trigger output |

## Verification
A trigger edge that sets the flag and a software write that clears it can land on the same clock edge. To provoke this, the bench takes a running timer, drops its pin, raises it again and times a clear-flag write so that it lands on the edge where the new trigger edge registers. The flag must read 1 afterwards. The counter must have advanced by exactly three counts since the pin rose, which shows the second edge did not restart the count. A second case puts an update strobe on the same edge as an increment and expects 0, then 1 on the next cycle.

// File: rtl/ttp_pkg.sv
package ttp_pkg;
  localparam int CTRL_W = 11;

  localparam logic [2:0] TS_EXT  = 3'b100;
  localparam logic [2:0] TS_PEER = 3'b001;
  localparam logic [2:0] SM_TRIG = 3'b110;
  localparam logic [2:0] MM_UG   = 3'b000;
  localparam logic [2:0] MM_EN   = 3'b001;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_UG   = 2'd1,
    REG_CNT  = 2'd2,
    REG_FLAG = 2'd3
  } reg_e;

  typedef struct packed {
    logic       freeze;
    logic       msm;
    logic [2:0] mm;
    logic [2:0] sm;
    logic [2:0] ts;
  } ctrl_t;
endpackage

// File: rtl/ttp_sync.sv
module ttp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ttp_trig_in.sv
module ttp_trig_in
  import ttp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] ts_i,
  input  logic       ext_i,
  input  logic       peer_i,
  output logic       edge_o
);
  logic trg_raw, trg_prev_q;

  always_comb begin
    unique case (ts_i)
      TS_EXT:  trg_raw = ext_i;
      TS_PEER: trg_raw = peer_i;
      default: trg_raw = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trg_prev_q <= 1'b0;
    else         trg_prev_q <= trg_raw;
  end

  assign edge_o = trg_raw & ~trg_prev_q;
endmodule

// File: rtl/ttp_timer.sv
module ttp_timer
  import ttp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  reg_e             reg_i,
  input  logic [CNT_W-1:0] data_i,
  input  logic             ext_trig_i,
  input  logic             peer_trgo_i,
  input  logic             dbg_halt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tif_o,
  output logic             trgo_o
);
  ctrl_t            ctrl_q;
  logic             cnt_en_q, en_dly_q, ug_q, tif_q;
  logic [CNT_W-1:0] cnt_q;
  logic             trg_edge, trig_fire, tick;
  logic             ctrl_wr, ug_wr, cnt_wr, flag_clr;

  assign ctrl_wr  = we_i && (reg_i == REG_CTRL);
  assign ug_wr    = we_i && (reg_i == REG_UG) && data_i[0];
  assign cnt_wr   = we_i && (reg_i == REG_CNT);
  assign flag_clr = we_i && (reg_i == REG_FLAG) && !data_i[0];

  ttp_trig_in u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ts_i   (ctrl_q.ts),
    .ext_i  (ext_trig_i),
    .peer_i (peer_trgo_i),
    .edge_o (trg_edge)
  );

  assign trig_fire = trg_edge && (ctrl_q.sm == SM_TRIG);
  // compensation: master counts one cycle late to match its slave
  assign tick = (ctrl_q.msm ? en_dly_q : cnt_en_q) && !(dbg_halt_i && ctrl_q.freeze);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      cnt_en_q <= 1'b0;
      en_dly_q <= 1'b0;
      ug_q     <= 1'b0;
    end else begin
      if (ctrl_wr)   ctrl_q   <= ctrl_t'(data_i[CTRL_W-1:0]);
      if (trig_fire) cnt_en_q <= 1'b1;
      en_dly_q <= cnt_en_q;
      ug_q     <= ug_wr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (ug_wr)  cnt_q <= '0;
    else if (cnt_wr) cnt_q <= data_i;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  // set has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tif_q <= 1'b0;
    else if (trig_fire) tif_q <= 1'b1;
    else if (flag_clr)  tif_q <= 1'b0;
  end

  always_comb begin
    unique case (ctrl_q.mm)
      MM_UG:   trgo_o = ug_q;
      MM_EN:   trgo_o = cnt_en_q;
      default: trgo_o = 1'b0;
    endcase
  end

  assign cnt_o = cnt_q;
  assign tif_o = tif_q;
endmodule

// File: rtl/trig_timer_pair.sv
module trig_timer_pair
  import ttp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_trig_i,
  input  logic             dbg_halt_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_a_o,
  output logic [CNT_W-1:0] cnt_b_o,
  output logic             tif_a_o,
  output logic             tif_b_o,
  output logic             trgo_a_o,
  output logic             trgo_b_o
);
  localparam int N_TMR = 2;

  logic                        ext_sync;
  logic [N_TMR-1:0][CNT_W-1:0] cnt;
  logic [N_TMR-1:0]            tif;
  logic [N_TMR-1:0]            trgo;

  ttp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ext_trig_i),
    .q_o    (ext_sync)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : gen_tmr
    ttp_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .we_i        (wr_en_i && (wr_addr_i[2] == 1'(i))),
      .reg_i       (reg_e'(wr_addr_i[1:0])),
      .data_i      (wr_data_i),
      .ext_trig_i  (ext_sync),
      .peer_trgo_i (trgo[N_TMR-1-i]),
      .dbg_halt_i  (dbg_halt_i),
      .cnt_o       (cnt[i]),
      .tif_o       (tif[i]),
      .trgo_o      (trgo[i])
    );
  end

  assign cnt_a_o  = cnt[0];
  assign cnt_b_o  = cnt[1];
  assign tif_a_o  = tif[0];
  assign tif_b_o  = tif[1];
  assign trgo_a_o = trgo[0];
  assign trgo_b_o = trgo[1];
endmodule

// File: rtl/ttp_checker.sv
module ttp_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_addr_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] cnt_a_o,
  input logic [CNT_W-1:0] cnt_b_o,
  input logic             tif_a_o,
  input logic             tif_b_o
);
  logic clr_a, clr_b, ug_a, ld_a;
  assign clr_a = wr_en_i && (wr_addr_i == 3'd3) && !wr_data_i[0];
  assign clr_b = wr_en_i && (wr_addr_i == 3'd7) && !wr_data_i[0];
  assign ug_a  = wr_en_i && (wr_addr_i == 3'd1) && wr_data_i[0];
  assign ld_a  = wr_en_i && (wr_addr_i == 3'd2);

  AST_TIF_A_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tif_a_o && !clr_a) |=> tif_a_o); // R11
  AST_TIF_B_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tif_b_o && !clr_b) |=> tif_b_o); // R11
  AST_UG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_a |=> (cnt_a_o == '0)); // R7
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_a |=> (cnt_a_o == $past(wr_data_i))); // R8
  AST_CNT_A_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((cnt_a_o == $past(cnt_a_o)) || (cnt_a_o == $past(cnt_a_o) + CNT_W'(1)))); // R9
  AST_CNT_B_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((cnt_b_o == $past(cnt_b_o)) || (cnt_b_o == $past(cnt_b_o) + CNT_W'(1)))); // R9
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && (cnt_a_o != '0) && (cnt_a_o != '1)) |=> (cnt_a_o != '0)); // R10
endmodule

bind trig_timer_pair ttp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .cnt_a_o   (cnt_a_o),
  .cnt_b_o   (cnt_b_o),
  .tif_a_o   (tif_a_o),
  .tif_b_o   (tif_b_o)
);

// File: tb/trig_timer_pair_test.sv
`timescale 1ns/1ps
module trig_timer_pair_test;
  localparam int CLK_NS = 8;

  logic        clk_i = 1'b0, rst_ni = 1'b0, ext_trig_i = 1'b0, dbg_halt_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] cnt_a_o, cnt_b_o;
  logic        tif_a_o, tif_b_o, trgo_a_o, trgo_b_o;

  int checks = 0, fails = 0;

  trig_timer_pair uut (.*);

  always #(CLK_NS/2) clk_i = ~clk_i;

  typedef struct packed {
    logic        msm;
    logic [15:0] pa, pb;
    logic [7:0]  k;
    logic [15:0] ea, eb;
  } vec_t;

  // counts sampled after edge Pk, P0 = first edge seeing the pin high
  localparam vec_t [0:4] VECS = '{
    '{1'b0, 16'd0,      16'd0,      8'd10, 16'd8,      16'd7},
    '{1'b1, 16'd0,      16'd0,      8'd10, 16'd7,      16'd7},
    '{1'b1, 16'd100,    16'd40,     8'd6,  16'd103,    16'd43},
    '{1'b0, 16'hFFFE,   16'hFFFE,   8'd5,  16'h0001,   16'h0000},
    '{1'b1, 16'hFFFF,   16'h0000,   8'd20, 16'h0010,   16'h0011}
  };

  localparam logic [15:0] CTRL_A = 16'h0074; // ts 100, sm 110, mm 001
  localparam logic [15:0] CTRL_B = 16'h0031; // ts 001, sm 110, mm 000

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_reset();
    ext_trig_i = 1'b0; dbg_halt_i = 1'b0; wr_en_i = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic start_pair(input logic msm, input logic [15:0] pa, input logic [15:0] pb);
    wr(3'd0, CTRL_A | (16'(msm) << 9));
    wr(3'd4, CTRL_B);
    wr(3'd1, 16'd1);
    wr(3'd5, 16'd1);
    wr(3'd2, pa);
    wr(3'd6, pb);
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] c0, cb0;
    do_reset();
    // R1 reset state
    chk("R1 cnt_a", cnt_a_o, 0);
    chk("R1 cnt_b", cnt_b_o, 0);
    chk("R1 flags", {tif_a_o, tif_b_o}, 0);
    chk("R1 trgo", {trgo_a_o, trgo_b_o}, 0);

    // vector walk: R2 R3 R4 R8 R9
    for (int v = 0; v < 5; v++) begin
      do_reset();
      start_pair(VECS[v].msm, VECS[v].pa, VECS[v].pb);
      ext_trig_i = 1'b1;
      repeat (int'(VECS[v].k) + 1) @(posedge clk_i);
      @(negedge clk_i);
      chk(VECS[v].msm ? "R4 cnt_a" : "R2 cnt_a", cnt_a_o, VECS[v].ea);
      chk("R3 cnt_b", cnt_b_o, VECS[v].eb);
      chk("R2 flags", {tif_a_o, tif_b_o}, 2'b11);
      begin
        logic [15:0] dexp;
        int bad;
        dexp = VECS[v].pa - VECS[v].pb + (VECS[v].msm ? 16'd0 : 16'd1);
        bad = 0;
        for (int c = 0; c < 8; c++) begin
          @(negedge clk_i);
          if (16'(cnt_a_o - cnt_b_o) !== dexp) bad++;
        end
        chk(VECS[v].msm ? "R4 align" : "R3 lead", bad, 0);
      end
    end

    // R2 flag timing and R11 flag behaviour
    do_reset();
    start_pair(1'b1, 16'd0, 16'd0);
    ext_trig_i = 1'b1;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    chk("R2 tif_a before P2", tif_a_o, 0);
    @(negedge clk_i);
    chk("R2 tif_a at P2", tif_a_o, 1);
    chk("R3 tif_b at P2", tif_b_o, 0);
    @(negedge clk_i);
    chk("R3 tif_b at P3", tif_b_o, 1);
    wr(3'd3, 16'd1);
    chk("R11 write 1 no effect", tif_a_o, 1);
    wr(3'd3, 16'd0);
    chk("R11 clear", tif_a_o, 0);
    ext_trig_i = 1'b0;
    repeat (4) @(negedge clk_i);
    // re-edge and clearing write land together at P2
    c0 = cnt_a_o;
    ext_trig_i = 1'b1;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'd3; wr_data_i = 16'd0;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R11 set beats clear", tif_a_o, 1);
    chk("R10 no restart", cnt_a_o, 32'(16'(c0 + 16'd3)));

    // R7 update strobe beats increment
    wr(3'd1, 16'd1);
    chk("R7 ug zero", cnt_a_o, 0);
    @(negedge clk_i);
    chk("R7 counts after ug", cnt_a_o, 1);

    // R12 freeze
    wr(3'd0, CTRL_A | 16'h0600);
    wr(3'd4, CTRL_B | 16'h0400);
    dbg_halt_i = 1'b1;
    c0 = cnt_a_o; cb0 = cnt_b_o;
    repeat (5) @(negedge clk_i);
    chk("R12 freeze a", cnt_a_o, c0);
    chk("R12 freeze b", cnt_b_o, cb0);
    dbg_halt_i = 1'b0;
    wr(3'd0, CTRL_A | 16'h0200);
    dbg_halt_i = 1'b1;
    c0 = cnt_a_o;
    repeat (3) @(negedge clk_i);
    chk("R12 no freeze bit", cnt_a_o, 32'(16'(c0 + 16'd3)));
    dbg_halt_i = 1'b0;

    // R5 non-trigger slave mode
    do_reset();
    wr(3'd0, 16'h0044);
    ext_trig_i = 1'b1;
    repeat (8) @(negedge clk_i);
    chk("R5 cnt_a idle", cnt_a_o, 0);
    chk("R5 tif_a idle", tif_a_o, 0);
    chk("R5 trgo_a idle", trgo_a_o, 0);

    // R6 update pulse as trigger output
    do_reset();
    wr(3'd0, 16'h0000);
    wr(3'd4, CTRL_B);
    wr(3'd1, 16'd1);
    chk("R6 ug pulse high", trgo_a_o, 1);
    @(negedge clk_i);
    chk("R6 ug pulse low", trgo_a_o, 0);
    chk("R6 b triggered", tif_b_o, 1);

    // R6 reserved master mode
    do_reset();
    wr(3'd0, 16'h0080);
    wr(3'd4, CTRL_B);
    wr(3'd1, 16'd1);
    chk("R6 reserved trgo", trgo_a_o, 0);
    repeat (4) @(negedge clk_i);
    chk("R6 b not triggered", tif_b_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule